// File: doc/BRIEF.md
# Paced Energy Pulse Output with Width Limit

A metering computation engine produces pulse-level requests in a burst of six per multiplexer frame. Driving an LED pin directly from those bursts would crowd all edges into a few cycles. This block takes each requested level and spreads the requests evenly in time. It queues them in a small FIFO and releases one at every release slot. A slot falls after a programmable number of fast-clock ticks, and the frame sync realigns the slot timer to the start of each frame.

While pacing is active, the block also limits how long the output may stay in its active state. If the active request lasts too long, the output is forced inactive. It stays inactive until the request goes inactive and then active again. When the interval register is zero, pacing and the width limit are both bypassed, and each request drives the pin on the next clock. A polarity bit selects an active-low output (the default, for sinking LED current) or an active-high output.

Top module: `pulse_pacer`

## Requirements
- R1: While rst_ni is low, and after it is released with no further stimulus, pulse_o is at the inactive level: 1 when inv_i is 0. The FIFO is empty and all counters are zero.
- R2: When interval_i is 0, a strobe on upd_i makes upd_lvl_i the requested level (1 = active) from the next clock edge on. This happens whatever tick_i is doing. In this mode no width limit applies, however long the level stays active.
- R3: When interval_i is not 0, each strobe queues its level in a FIFO. A release slot occurs on the cycle where tick_i is high and the tick count since the last slot or frame sync reaches 4*interval_i. At a slot, one entry is popped and becomes the requested level, and pulse_o shows it from the following edge. Between slots the requested level does not change.
- R4: A cycle with frame_i high restarts the slot tick count at zero, and no release happens in that cycle.
- R5: If the FIFO is empty at a slot, the requested level keeps its previous value.
- R6: The FIFO holds DEPTH (8) entries. A strobe that finds it full, with no pop in the same cycle, is dropped.
- R7: With maxw_i = M not 255, suppose an active level is taken at slot k after an inactive one. If the request is still active at slot k+2M+1, the output is forced inactive from that slot on.
- R8: Once the output has been forced inactive, further active releases keep it inactive. It becomes active again only at a slot where the requested level changes from inactive to active.
- R9: With maxw_i = 255, no width limit applies in paced mode.
- R10: pulse_o equals the inverse of the effective active state when inv_i is 0, and equals the active state when inv_i is 1. It follows inv_i in the same cycle.
- R11: With tick_i low, no slot occurs and queued entries stay unreleased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fast clock enable, one pulse per timing tick |
| frame_i | input | 1 | Multiplexer frame sync |
| upd_i | input | 1 | Update strobe from the computation engine |
| upd_lvl_i | input | 1 | Requested level with the strobe, 1 = active |
| interval_i | input | 8 | Slot spacing in units of 4 ticks; 0 bypasses pacing |
| maxw_i | input | 8 | Width limit M, active time capped at 2M+1 slots; 255 disables |
| inv_i | input | 1 | 1 = active-high output, 0 = active-low |
| pulse_o | output | 1 | Pulse pin |

## Verification
In bypass mode a strobe that is sampled at a rising edge shows on pulse_o right after that edge. In paced mode a slot falls on the edge where the 4*interval-th tick is sampled, and pulse_o changes right after that edge. The polarity bit acts within the same cycle. The bench drives inputs 1 ns after each rising edge. It advances a queue-based reference model at the same rising edge, compares pulse_o against that model at every falling edge, and places its directed checks at slot edges counted from a frame sync.

// File: rtl/pulse_pacer_pkg.sv
package pulse_pacer_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned PRE_SHIFT = 2;              // slot = interval * 4 ticks
  localparam int unsigned CNT_W     = REG_W + PRE_SHIFT;
  localparam int unsigned WID_W     = REG_W + 1;      // holds 2*M
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_pop, do_push;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign do_push = push_i && !clr_i && (!full || do_pop);
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= adv(wr_q);
      if (do_pop)  rd_q <= adv(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pp_slot_timer.sv
module pp_slot_timer
  import pulse_pacer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic frame_i,
  input  reg_t interval_i,
  output logic slot_o
);
  logic [CNT_W-1:0] cnt_q, last;
  logic             en;

  assign en     = |interval_i;
  assign last   = {interval_i, {PRE_SHIFT{1'b0}}} - CNT_W'(1);
  // >= so a shrunk interval cannot strand the counter past its limit
  assign slot_o = en && tick_i && !frame_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en || frame_i)     cnt_q <= '0;
    else if (slot_o)             cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pp_width_lim.sv
module pp_width_lim
  import pulse_pacer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic upd_i,
  input  logic upd_lvl_i,
  input  logic slot_i,
  input  logic slot_lvl_i,
  input  reg_t maxw_i,
  output logic req_o,
  output logic act_o
);
  logic             req_q, cut_q;
  logic [WID_W-1:0] w_q, limit;
  logic             chk_on;

  assign limit  = {maxw_i, 1'b0};
  assign chk_on = (maxw_i != '1);
  assign req_o  = req_q;
  assign act_o  = req_q & ~cut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; cut_q <= 1'b0; w_q <= '0;
    end else if (bypass_i) begin
      if (upd_i) req_q <= upd_lvl_i;
      cut_q <= 1'b0;
      w_q   <= '0;
    end else if (slot_i) begin
      if (!slot_lvl_i || !req_q) begin   // inactive, or fresh activation
        w_q   <= '0;
        cut_q <= 1'b0;
      end else if (chk_on && !cut_q) begin
        if (w_q == limit) cut_q <= 1'b1;
        else              w_q   <= w_q + 1'b1;
      end
      req_q <= slot_lvl_i;
    end
  end
endmodule

// File: rtl/pulse_pacer.sv
module pulse_pacer
  import pulse_pacer_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frame_i,
  input  logic             upd_i,
  input  logic             upd_lvl_i,
  input  logic [REG_W-1:0] interval_i,
  input  logic [REG_W-1:0] maxw_i,
  input  logic             inv_i,
  output logic             pulse_o
);
  logic paced, slot, req, act;
  logic fifo_lvl, fifo_empty, slot_lvl;

  assign paced = |interval_i;

  pp_fifo #(.DEPTH(DEPTH), .W(1)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!paced),
    .push_i  (upd_i & paced),
    .data_i  (upd_lvl_i),
    .pop_i   (slot),
    .data_o  (fifo_lvl),
    .empty_o (fifo_empty)
  );

  pp_slot_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .frame_i    (frame_i),
    .interval_i (interval_i),
    .slot_o     (slot)
  );

  assign slot_lvl = fifo_empty ? req : fifo_lvl;

  pp_width_lim u_wlim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bypass_i   (!paced),
    .upd_i      (upd_i),
    .upd_lvl_i  (upd_lvl_i),
    .slot_i     (slot),
    .slot_lvl_i (slot_lvl),
    .maxw_i     (maxw_i),
    .req_o      (req),
    .act_o      (act)
  );

  assign pulse_o = ~(act ^ inv_i);
endmodule

// File: rtl/pulse_pacer_chk.sv
module pulse_pacer_chk
  import pulse_pacer_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             frame_i,
  input logic             upd_i,
  input logic             upd_lvl_i,
  input logic [REG_W-1:0] interval_i,
  input logic [REG_W-1:0] maxw_i,
  input logic             slot_i,
  input logic             req_i,
  input logic             act_i
);
  logic [CNT_W:0] gap_q;
  logic           gap_ok_q;
  reg_t           iv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; gap_ok_q <= 1'b0; iv_q <= '0;
    end else begin
      iv_q <= interval_i;
      if (interval_i != iv_q) begin
        gap_q <= '0; gap_ok_q <= 1'b0;
      end else if (frame_i || slot_i) begin
        gap_q <= '0; gap_ok_q <= 1'b1;
      end else if (tick_i) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_bypass_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0 && upd_i) |=> (req_i == $past(upd_lvl_i)));

  assert_hold_between_slots_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i != '0 && !slot_i) |=> $stable(act_i));

  assert_slot_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && gap_ok_q && interval_i == iv_q) |->
      (gap_q == ({1'b0, interval_i, {PRE_SHIFT{1'b0}}} - 1'b1)));

  assert_frame_no_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |-> !slot_i);

  assert_no_limit_at_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(act_i) && req_i && $past(req_i)) |-> ($past(maxw_i) != 8'hFF));

  assert_tick_needed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |-> tick_i);
endmodule

bind pulse_pacer pulse_pacer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .frame_i    (frame_i),
  .upd_i      (upd_i),
  .upd_lvl_i  (upd_lvl_i),
  .interval_i (interval_i),
  .maxw_i     (maxw_i),
  .slot_i     (slot),
  .req_i      (req),
  .act_i      (act)
);

// File: tb/sim_pulse_pacer.sv
`timescale 1ns/1ps
module sim_pulse_pacer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b1, frame = 1'b0, upd = 1'b0, lvl = 1'b0, inv = 1'b0;
  logic [7:0] iv = 8'd0, mw = 8'd0;
  logic       pulse;

  int    n_chk = 0, n_fail = 0;
  bit    run = 0, done = 0;
  string cur_req = "R1";

  // reference model
  bit m_q[$];
  int m_cnt = 0, m_w = 0;
  bit m_req = 0, m_cut = 0, m_slot, m_nl;

  always #5 clk = ~clk;

  pulse_pacer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .frame_i(frame),
    .upd_i(upd), .upd_lvl_i(lvl), .interval_i(iv), .maxw_i(mw),
    .inv_i(inv), .pulse_o(pulse)
  );

  function automatic logic pin(bit a, logic i);
    return ~(a ^ i);
  endfunction

  task automatic check(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pulse_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_cnt = 0; m_w = 0; m_req = 0; m_cut = 0;
    end else if (iv == 0) begin
      m_q.delete(); m_cnt = 0; m_w = 0; m_cut = 0;
      if (upd) m_req = lvl;
    end else begin
      m_slot = 0;
      if (frame) m_cnt = 0;
      else if (tick) begin
        if (m_cnt >= 4 * int'(iv) - 1) begin m_slot = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (m_slot) begin
        m_nl = (m_q.size() > 0) ? m_q.pop_front() : m_req;
        if (!m_nl || !m_req) begin m_w = 0; m_cut = 0; end
        else if (mw != 8'hFF && !m_cut) begin
          if (m_w == 2 * int'(mw)) m_cut = 1; else m_w++;
        end
        m_req = m_nl;
      end
      if (upd && m_q.size() < 8) m_q.push_back(lvl);
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) check(pulse, pin(m_req & ~m_cut, inv), cur_req);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit l);
    upd = 1'b1; lvl = l;
    cyc(1);
    upd = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): run not finished, expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7717));
    cyc(3);
    check(pulse, 1'b1, "R1");            // inactive during reset
    rst_n = 1'b1;
    cyc(2);
    check(pulse, 1'b1, "R1");
    run = 1;

    // R2: bypass, tick ignored, no width limit
    cur_req = "R2"; iv = 0; mw = 0; tick = 0;
    wr(1);
    check(pulse, 1'b0, "R2");
    cyc(40);
    check(pulse, 1'b0, "R2");
    wr(0);
    check(pulse, 1'b1, "R2");

    // R10: polarity
    cur_req = "R10";
    inv = 1; #1;
    check(pulse, 1'b0, "R10");
    wr(1);
    check(pulse, 1'b1, "R10");
    inv = 0; #1;
    check(pulse, 1'b0, "R10");
    wr(0);
    check(pulse, 1'b1, "R10");

    // R3/R7/R8: interval 1 (slot every 4 ticks), M = 0
    cur_req = "R7"; iv = 1; mw = 0; tick = 1;
    frame = 1; upd = 1; lvl = 1;
    cyc(1);                               // E0
    frame = 0; upd = 0;
    cyc(3); check(pulse, 1'b1, "R3");     // E3
    cyc(1); check(pulse, 1'b0, "R3");     // E4 slot
    cyc(4); check(pulse, 1'b1, "R7");     // E8 cut after 1 slot
    cur_req = "R8";
    wr(1);                                // E9
    cyc(3); check(pulse, 1'b1, "R8");     // E12 active again, still cut
    wr(0); wr(1);                         // E13, E14
    cyc(2); check(pulse, 1'b1, "R8");     // E16 inactive
    cyc(4); check(pulse, 1'b0, "R8");     // E20 re-armed

    // R5/R9: M = 255, empty slots hold level
    cur_req = "R9"; mw = 8'hFF;
    frame = 1; upd = 1; lvl = 1;
    cyc(1);
    frame = 0; upd = 0;
    cyc(4);  check(pulse, 1'b0, "R9");
    cyc(12); check(pulse, 1'b0, "R5");
    check(pulse, 1'b0, "R9");

    // R4: frame sync restarts slot count
    cur_req = "R4";
    frame = 1; upd = 1; lvl = 0;
    cyc(1);                               // E0
    frame = 0; upd = 0;
    cyc(4); check(pulse, 1'b1, "R4");     // E4 inactive
    cyc(1);
    frame = 1; upd = 1; lvl = 1;
    cyc(1);                               // E6 frame
    frame = 0; upd = 0;
    cyc(2); check(pulse, 1'b1, "R4");     // E8 no slot
    cyc(2); check(pulse, 1'b0, "R4");     // E10 slot

    // R11: no ticks, no release
    cur_req = "R11"; tick = 0;
    frame = 1; upd = 1; lvl = 0;
    cyc(1);
    frame = 0; upd = 0;
    cyc(30); check(pulse, 1'b0, "R11");
    tick = 1;
    cyc(4); check(pulse, 1'b1, "R11");

    // R6: overfill, entries 8 and 9 dropped
    cur_req = "R6"; tick = 0;
    frame = 1; cyc(1); frame = 0;
    for (int i = 0; i < 10; i++) wr((i >= 8) ? 1'b1 : (i % 2 == 0));
    tick = 1;
    cyc(4);  check(pulse, 1'b0, "R6");    // entry 0 active
    cyc(28); check(pulse, 1'b1, "R6");    // entry 7 inactive
    cyc(8);  check(pulse, 1'b1, "R6");    // no dropped entry released

    // R3: constrained random mix
    cur_req = "R3";
    for (int c = 0; c < 6000; c++) begin
      if (c % 500 == 0) begin
        case ($urandom % 5)
          0: iv = 0; 1: iv = 1; 2: iv = 2; 3: iv = 3; default: iv = 5;
        endcase
        case ($urandom % 4)
          0: mw = 0; 1: mw = 1; 2: mw = 3; default: mw = 8'hFF;
        endcase
        inv = $urandom % 2;
      end
      tick  = ($urandom % 4) != 0;
      frame = ($urandom % 150) == 0;
      upd   = ($urandom % 5) == 0;
      lvl   = $urandom % 2;
      cyc(1);
    end
    upd = 0; frame = 0;
    cyc(2);
    run = 0;
    summary();
    $finish;
  end
endmodule